// File: doc/BRIEF.md
# Periodic Interrupt Timer With Reload

This block is a down-counting timer that advances once for each pulse on a slow tick-enable input, for example an 8192 Hz strobe taken from the system clock. Software sets it up through a small register window with three words: a control/status word, a period word and a read-only view of the live count. While the timer runs, it steps the count down by one on each tick. On the tick that finds the count at zero, the counter wraps. It reloads from the period word when automatic reload is on, or rolls over to all-ones when it is off. The same tick sets a sticky event flag.

The flag drives the interrupt request output whenever the interrupt enable is set. An external interrupt controller takes that line. Software clears the flag by writing a one to its bit. The programmed period value N gives one event every N+1 ticks. An optional immediate-load mode copies any period write straight into the running counter. When that mode is off, a new period takes effect at the next wrap.

Top module: `tick_timer`

## Requirements
- R1: After reset, the control word reads 0, the period and count words read all-ones, and irq_o is low.
- R2: While the run bit (control bit 0) is clear, ticks leave the count unchanged.
- R3: While running, the count drops by exactly one on each tick from a nonzero value. It holds in cycles without a tick.
- R4: With the autoload bit (control bit 1) set, a tick at count zero loads the period word and sets the flag (control bit 4). The flag therefore sets once every period+1 ticks.
- R5: With autoload clear, a tick at count zero loads all-ones into the count and sets the flag.
- R6: With the immediate-load bit (control bit 2) set, a write to the period word (address 1) puts the written value in the count on the next cycle. This holds even when a tick arrives in the same cycle.
- R7: With immediate-load clear, a period write leaves the count alone. The new value is used at the next wrap.
- R8: Writing 1 to control bit 4 clears the flag. Writing 0 there leaves it unchanged.
- R9: If a wrap and a write-1 clear of the flag happen in the same cycle, the flag ends up set.
- R10: irq_o is high exactly when the flag and the interrupt-enable bit (control bit 3) are both set. If the flag is already pending, irq_o rises the cycle after the enable is written.
- R11: Reads have no side effects. Address 2 returns the live count, and writes to address 2 are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | Slow timer tick enable, one clock wide |
| bus_wr_i | input | 1 | Register write strobe |
| bus_addr_i | input | 2 | Register address: 0 control, 1 period, 2 count |
| bus_wdata_i | input | CNT_W | Write data |
| bus_rdata_o | output | CNT_W | Read data for bus_addr_i, combinational |
| irq_o | output | 1 | Interrupt request to the external controller |

## Verification
The bound checker covers the following on every cycle:
- the counter freezing while stopped;
- single-step decrement;
- the reload and rollover values at a wrap;
- immediate load of the written value;
- the flag staying set unless it is cleared by a write of one;
- a wrap beating a same-cycle clear;
- the request line following the flag and the enable.

Only the bench scenarios can show the behaviours that need a sequence of events:
- the end-to-end event spacing of period+1 ticks;
- a deferred period write that takes effect only at the following wrap;
- the request rising as soon as the enable is written while a flag is pending;
- reads of the same word that repeat without disturbing it.

// File: rtl/tt_pkg.sv
package tt_pkg;

    // Register addresses
    localparam logic [1:0] ADDR_CTRL   = 2'd0;
    localparam logic [1:0] ADDR_PERIOD = 2'd1;
    localparam logic [1:0] ADDR_COUNT  = 2'd2;

    // Control word bit positions
    localparam int BIT_RUN   = 0;
    localparam int BIT_AUTO  = 1;
    localparam int BIT_LIVE  = 2;
    localparam int BIT_IEN   = 3;
    localparam int BIT_FLAG  = 4;
    localparam int CTRL_W    = 5;

    typedef struct packed {
        logic flag;
        logic irq_en;
        logic live_load;
        logic autoload;
        logic run;
    } ctrl_t;

endpackage

// File: rtl/tt_regs.sv
module tt_regs #(
    parameter int CNT_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr_i,
    input  logic [1:0]        bus_addr_i,
    input  logic [CNT_W-1:0]  bus_wdata_i,
    input  logic              wrap_i,
    output tt_pkg::ctrl_t     ctrl_o,
    output logic [CNT_W-1:0]  period_o
);
    import tt_pkg::*;

    typedef struct packed {
        ctrl_t            ctrl;
        logic [CNT_W-1:0] period;
    } regs_t;

    regs_t st_d, st_q;
    logic  ctrl_wr, period_wr, flag_clr;

    always_comb begin
        ctrl_wr   = bus_wr_i && (bus_addr_i == ADDR_CTRL);
        period_wr = bus_wr_i && (bus_addr_i == ADDR_PERIOD);
        flag_clr  = ctrl_wr && bus_wdata_i[BIT_FLAG];
        st_d      = st_q;
        if (ctrl_wr) begin
            st_d.ctrl.run       = bus_wdata_i[BIT_RUN];
            st_d.ctrl.autoload  = bus_wdata_i[BIT_AUTO];
            st_d.ctrl.live_load = bus_wdata_i[BIT_LIVE];
            st_d.ctrl.irq_en    = bus_wdata_i[BIT_IEN];
        end
        // a wrap event outranks a write-one clear
        if (wrap_i)        st_d.ctrl.flag = 1'b1;
        else if (flag_clr) st_d.ctrl.flag = 1'b0;
        if (period_wr)     st_d.period    = bus_wdata_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.ctrl   <= '0;
            st_q.period <= '1;
        end else begin
            st_q <= st_d;
        end
    end

    assign ctrl_o   = st_q.ctrl;
    assign period_o = st_q.period;

endmodule

// File: rtl/tt_count.sv
module tt_count #(
    parameter int CNT_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_i,
    input  tt_pkg::ctrl_t     ctrl_i,
    input  logic [CNT_W-1:0]  period_i,
    input  logic              load_i,
    input  logic [CNT_W-1:0]  load_val_i,
    output logic [CNT_W-1:0]  count_o,
    output logic              wrap_o
);
    typedef struct packed {
        logic [CNT_W-1:0] count;
    } cnt_t;

    cnt_t st_d, st_q;
    logic step, at_zero;

    always_comb begin
        step    = tick_i && ctrl_i.run;
        at_zero = (st_q.count == '0);
        wrap_o  = step && at_zero;
        st_d    = st_q;
        if (load_i) begin
            st_d.count = load_val_i;
        end else if (step) begin
            if (!at_zero)             st_d.count = st_q.count - 1'b1;
            else if (ctrl_i.autoload) st_d.count = period_i;
            else                      st_d.count = '1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q.count <= '1;
        else        st_q       <= st_d;
    end

    assign count_o = st_q.count;

endmodule

// File: rtl/tt_rdmux.sv
module tt_rdmux #(
    parameter int CNT_W = 16
) (
    input  logic [1:0]        addr_i,
    input  tt_pkg::ctrl_t     ctrl_i,
    input  logic [CNT_W-1:0]  period_i,
    input  logic [CNT_W-1:0]  count_i,
    output logic [CNT_W-1:0]  rdata_o
);
    import tt_pkg::*;

    localparam int PAD_W = CNT_W - CTRL_W;

    logic [CNT_W-1:0] ctrl_word;

    generate
        if (PAD_W > 0) begin : g_pad
            assign ctrl_word = {{PAD_W{1'b0}}, ctrl_i};
        end else begin : g_nopad
            assign ctrl_word = ctrl_i[CNT_W-1:0];
        end
    endgenerate

    always_comb begin
        case (addr_i)
            ADDR_CTRL:   rdata_o = ctrl_word;
            ADDR_PERIOD: rdata_o = period_i;
            ADDR_COUNT:  rdata_o = count_i;
            default:     rdata_o = '0;
        endcase
    end

endmodule

// File: rtl/tick_timer.sv
module tick_timer #(
    parameter int CNT_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_i,
    input  logic              bus_wr_i,
    input  logic [1:0]        bus_addr_i,
    input  logic [CNT_W-1:0]  bus_wdata_i,
    output logic [CNT_W-1:0]  bus_rdata_o,
    output logic              irq_o
);
    import tt_pkg::*;

    ctrl_t            ctrl_q;
    logic [CNT_W-1:0] period_q;
    logic [CNT_W-1:0] count_q;
    logic             wrap;
    logic             live_wr;

    assign live_wr = bus_wr_i && (bus_addr_i == ADDR_PERIOD) && ctrl_q.live_load;

    tt_regs #(.CNT_W(CNT_W)) u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .bus_wr_i    (bus_wr_i),
        .bus_addr_i  (bus_addr_i),
        .bus_wdata_i (bus_wdata_i),
        .wrap_i      (wrap),
        .ctrl_o      (ctrl_q),
        .period_o    (period_q)
    );

    tt_count #(.CNT_W(CNT_W)) u_count (
        .clk         (clk),
        .rst_n       (rst_n),
        .tick_i      (tick_i),
        .ctrl_i      (ctrl_q),
        .period_i    (period_q),
        .load_i      (live_wr),
        .load_val_i  (bus_wdata_i),
        .count_o     (count_q),
        .wrap_o      (wrap)
    );

    tt_rdmux #(.CNT_W(CNT_W)) u_rdmux (
        .addr_i      (bus_addr_i),
        .ctrl_i      (ctrl_q),
        .period_i    (period_q),
        .count_i     (count_q),
        .rdata_o     (bus_rdata_o)
    );

    assign irq_o = ctrl_q.flag && ctrl_q.irq_en;

endmodule

// File: rtl/tick_timer_chk.sv
module tick_timer_chk #(
    parameter int CNT_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              tick_i,
    input logic              bus_wr_i,
    input logic [1:0]        bus_addr_i,
    input logic [CNT_W-1:0]  bus_wdata_i,
    input logic              irq_o,
    input tt_pkg::ctrl_t     ctrl,
    input logic [CNT_W-1:0]  period,
    input logic [CNT_W-1:0]  count
);
    import tt_pkg::*;

    logic per_wr, lw, clr_wr, at_zero;
    assign per_wr  = bus_wr_i && (bus_addr_i == ADDR_PERIOD);
    assign lw      = per_wr && ctrl.live_load;
    assign clr_wr  = bus_wr_i && (bus_addr_i == ADDR_CTRL) && bus_wdata_i[BIT_FLAG];
    assign at_zero = (count == '0);

    p_frozen_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctrl.run && !lw) |=> $stable(count));

    p_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_i && ctrl.run && !at_zero && !lw) |=> (count == $past(count) - 1'b1));

    p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick_i && !lw) |=> $stable(count));

    p_reload_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_i && ctrl.run && at_zero && ctrl.autoload && !lw)
            |=> (count == $past(period)) && ctrl.flag);

    p_rollover_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_i && ctrl.run && at_zero && !ctrl.autoload && !lw)
            |=> (&count) && ctrl.flag);

    p_live_load_r6: assert property (@(posedge clk) disable iff (!rst_n)
        lw |=> (count == $past(bus_wdata_i)));

    p_period_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !per_wr |=> $stable(period));

    p_flag_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl.flag && !clr_wr) |=> ctrl.flag);

    p_set_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_i && ctrl.run && at_zero && clr_wr) |=> ctrl.flag);

    p_irq_on_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl.flag && ctrl.irq_en) |-> irq_o);

    p_irq_off_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctrl.flag || !ctrl.irq_en) |-> !irq_o);

endmodule

bind tick_timer tick_timer_chk #(.CNT_W(CNT_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .tick_i      (tick_i),
    .bus_wr_i    (bus_wr_i),
    .bus_addr_i  (bus_addr_i),
    .bus_wdata_i (bus_wdata_i),
    .irq_o       (irq_o),
    .ctrl        (ctrl_q),
    .period      (period_q),
    .count       (count_q)
);

// File: tb/tick_timer_bench.sv
module tick_timer_bench;

    localparam int W = 16;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         tick_i = 1'b0;
    logic         bus_wr_i = 1'b0;
    logic [1:0]   bus_addr_i = 2'd0;
    logic [W-1:0] bus_wdata_i = '0;
    logic [W-1:0] bus_rdata_o;
    logic         irq_o;

    int n_checks = 0;
    int n_fails  = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    tick_timer #(.CNT_W(W)) u_tick_timer (
        .clk         (clk),
        .rst_n       (rst_n),
        .tick_i      (tick_i),
        .bus_wr_i    (bus_wr_i),
        .bus_addr_i  (bus_addr_i),
        .bus_wdata_i (bus_wdata_i),
        .bus_rdata_o (bus_rdata_o),
        .irq_o       (irq_o)
    );

    typedef struct {
        bit           is_irq;
        logic [W-1:0] exp;
        string        req;
    } item_t;

    item_t sbq[$];

    // Monitor: pops expected items and compares against the outputs
    initial begin
        forever begin
            item_t it;
            wait (sbq.size() != 0);
            #1;
            it = sbq.pop_front();
            n_checks++;
            if (it.is_irq) begin
                if (irq_o !== it.exp[0]) begin
                    n_fails++;
                    $display("FAIL %s: irq_o actual %0b expected %0b", it.req, irq_o, it.exp[0]);
                end
            end else if (bus_rdata_o !== it.exp) begin
                n_fails++;
                $display("FAIL %s: rdata actual %h expected %h", it.req, bus_rdata_o, it.exp);
            end
        end
    end

    task automatic exp_rd(input logic [1:0] a, input logic [W-1:0] e, input string r);
        item_t it;
        bus_addr_i = a;
        it.is_irq = 1'b0; it.exp = e; it.req = r;
        sbq.push_back(it);
        wait (sbq.size() == 0);
        #1;
    endtask

    task automatic exp_irq(input logic e, input string r);
        item_t it;
        it.is_irq = 1'b1; it.exp = {{(W-1){1'b0}}, e}; it.req = r;
        sbq.push_back(it);
        wait (sbq.size() == 0);
        #1;
    endtask

    task automatic wr(input logic [1:0] a, input logic [W-1:0] d, input logic t);
        @(negedge clk);
        bus_wr_i = 1'b1; bus_addr_i = a; bus_wdata_i = d; tick_i = t;
        @(negedge clk);
        bus_wr_i = 1'b0; tick_i = 1'b0;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); tick_i = 1'b1;
            @(negedge clk); tick_i = 1'b0;
        end
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
    endtask

    initial begin
        #(8 * 100000);
        if (!finished) begin
            n_checks++; n_fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset values
        exp_rd(2'd0, 16'h0000, "R1 ctrl");
        exp_rd(2'd1, 16'hFFFF, "R1 period");
        exp_rd(2'd2, 16'hFFFF, "R1 count");
        exp_irq(1'b0, "R1 irq");
        // R7 deferred period write, R2 stopped counter
        wr(2'd1, 16'd5, 1'b0);
        exp_rd(2'd1, 16'd5, "R7 period stored");
        exp_rd(2'd2, 16'hFFFF, "R7 count untouched");
        ticks(2);
        exp_rd(2'd2, 16'hFFFF, "R2 frozen while stopped");
        // R3 step and hold
        wr(2'd0, 16'h0003, 1'b0);
        ticks(1);
        exp_rd(2'd2, 16'hFFFE, "R3 one step");
        repeat (3) @(negedge clk);
        exp_rd(2'd2, 16'hFFFE, "R3 hold without tick");
        // R6 immediate load
        wr(2'd0, 16'h0007, 1'b0);
        wr(2'd1, 16'd3, 1'b0);
        exp_rd(2'd2, 16'd3, "R6 immediate load");
        // R4 reload and period+1 spacing
        ticks(3);
        exp_rd(2'd2, 16'd0, "R4 reached zero");
        exp_rd(2'd0, 16'h0007, "R4 no flag before wrap");
        ticks(1);
        exp_rd(2'd2, 16'd3, "R4 reload value");
        exp_rd(2'd0, 16'h0017, "R4 flag on wrap");
        // R8 write-one-to-clear
        wr(2'd0, 16'h0007, 1'b0);
        exp_rd(2'd0, 16'h0017, "R8 write zero keeps flag");
        wr(2'd0, 16'h0017, 1'b0);
        exp_rd(2'd0, 16'h0007, "R8 write one clears flag");
        ticks(3);
        exp_rd(2'd0, 16'h0007, "R4 no flag after 3 ticks");
        ticks(1);
        exp_rd(2'd0, 16'h0017, "R4 flag after 4 ticks");
        // R10 interrupt gating
        exp_irq(1'b0, "R10 irq masked");
        wr(2'd0, 16'h000F, 1'b0);
        exp_irq(1'b1, "R10 irq on enable with pending flag");
        wr(2'd0, 16'h001F, 1'b0);
        exp_irq(1'b0, "R10 irq drops on clear");
        // R9 set beats clear
        ticks(3);
        exp_rd(2'd2, 16'd0, "R9 at zero");
        wr(2'd0, 16'h001F, 1'b1);
        exp_rd(2'd0, 16'h001F, "R9 set wins over clear");
        exp_rd(2'd2, 16'd3, "R9 reload in same cycle");
        exp_irq(1'b1, "R10 irq with flag and enable");
        // R7 deferred period used at next wrap
        wr(2'd0, 16'h0013, 1'b0);
        exp_rd(2'd0, 16'h0003, "R8 clear with new control");
        wr(2'd1, 16'd7, 1'b0);
        exp_rd(2'd2, 16'd3, "R7 count unchanged by write");
        ticks(4);
        exp_rd(2'd2, 16'd7, "R7 new period at wrap");
        // R5 rollover without autoload
        wr(2'd0, 16'h0011, 1'b0);
        ticks(7);
        exp_rd(2'd2, 16'd0, "R5 at zero");
        ticks(1);
        exp_rd(2'd2, 16'hFFFF, "R5 rollover to all-ones");
        exp_rd(2'd0, 16'h0011, "R5 flag on rollover");
        // R11 read-only count, reads side-effect free
        wr(2'd2, 16'h1234, 1'b0);
        exp_rd(2'd2, 16'hFFFF, "R11 count write ignored");
        exp_rd(2'd2, 16'hFFFF, "R11 repeated count read");
        exp_rd(2'd0, 16'h0011, "R11 ctrl read 1");
        exp_rd(2'd0, 16'h0011, "R11 ctrl read 2");
        // R6 load beats same-cycle tick
        wr(2'd0, 16'h0005, 1'b0);
        wr(2'd1, 16'd9, 1'b1);
        exp_rd(2'd2, 16'd9, "R6 load wins over tick");
        finished = 1'b1;
        summary();
        $finish;
    end

endmodule